// File: doc/BRIEF.md
# Bridge Error Detection and Reporting Unit

This block sits beside a bridge between a processor-local bus and PCI and collects the error strobes raised by the bridge's bus interfaces. Each of seven error sources can be disabled with its own detection mask bit. An error whose detection mask bit is clear is latched into a sticky status register, which software clears by writing ones. The first error recorded since status was last empty is also captured by type.

Three reporting outputs are derived from the recorded status: an active-low system-error line, an active-low parity-error line and a 16-bit local-bus master error vector holding one bit per offending master ID. Each output has its own report mask bit. Detection masks and report masks are independent, so an error can be recorded in status without any output moving.

Register writes use a small address space. Address 0 holds the detection mask, with wdata bit i masking source i. Address 1 holds the report mask: bit 0 for the system-error line, bit 1 for the parity-error line and bit 2 for the master error vector. Address 2 is the write-1-to-clear status port. Error source indices are fixed: 0 local-bus unsupported transfer, 1 master abort issued as PCI master, 2 target abort received as PCI master, 3 PCI target data parity, 4 PCI master data parity, 5 PCI target address parity, 6 local-bus master error. Sources 0 and 6 are local-bus errors and carry a master ID. The rest are PCI errors.

Top module: `bridge_err_unit`

## Requirements
- R1: After reset, status is 0, no first error is valid, serr_no and perr_no are 1, merr_o is 0, and both masks are 0.
- R2: A strobe on err_evt_i[i] with detection mask bit i clear sets status bit i after the next rising edge. The bit then stays set until it is cleared.
- R3: A strobe on a source whose detection mask bit (address 0, bit i) is set leaves status, first-error capture and all reporting outputs unchanged.
- R4: A write to address 2 clears each status bit whose wdata bit is 1 and leaves the bits written with 0 unchanged. A new strobe on a bit in the same cycle as its clear leaves that bit set.
- R5: serr_no is 0 while status bit 2 or bit 5 is set and report mask bit 0 is clear. Otherwise it is 1.
- R6: perr_no is 0 while status bit 3 or bit 4 is set and report mask bit 1 is clear. Otherwise it is 1.
- R7: A recorded local-bus error (source 0 or 6) sets bit err_mid_i of the master error vector. The vector is cleared one cycle after status bits 0 and 6 are both clear. merr_o shows the vector unless report mask bit 2 is set, in which case merr_o is 0.
- R8: Report masks do not affect detection. Status bits are captured while outputs are masked, and clearing a report mask bit exposes errors that are already recorded.
- R9: first_vld_o and first_type_o hold the index of the earliest recorded error; among simultaneous strobes the lowest index wins. The capture stays unchanged while any status bit remains set and becomes invalid when status becomes all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_evt_i | input | 7 | One-cycle error strobes, one per source |
| err_mid_i | input | 4 | Master ID of the local-bus transfer that raised a local-bus error |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 detection mask, 1 report mask, 2 status clear |
| reg_wdata_i | input | 16 | Register write data |
| status_o | output | 7 | Sticky error status |
| first_vld_o | output | 1 | First-error capture valid |
| first_type_o | output | 3 | Index of the first recorded error |
| serr_no | output | 1 | Active-low system error report |
| perr_no | output | 1 | Active-low parity error report |
| merr_o | output | 16 | Local-bus master error vector, one bit per master ID |

## Verification
The assertions assume that err_mid_i is valid in every cycle that carries a local-bus strobe. They also assume that only one master ID is reported per cycle, so at most one vector bit is set per edge. Every strobe lasts exactly one cycle, and strobes and register writes are driven only on the falling edge. Each local-bus strobe is issued with its own ID, and simultaneous strobes are used only across PCI sources. Under these conditions the set-after-strobe and clear-after-write properties line up with the edge the bench samples after.

// File: rtl/bridge_err_pkg.sv
package bridge_err_pkg;
  localparam int NUM_ERR = 7;
  localparam int TYPE_W  = $clog2(NUM_ERR);

  typedef logic [NUM_ERR-1:0] err_vec_t;

  localparam int ERR_LB_UNSUP  = 0;
  localparam int ERR_PCI_MABT  = 1;
  localparam int ERR_PCI_TABT  = 2;
  localparam int ERR_TGT_DPAR  = 3;
  localparam int ERR_MST_DPAR  = 4;
  localparam int ERR_TGT_APAR  = 5;
  localparam int ERR_LB_MERR   = 6;

  localparam err_vec_t SERR_SEL  = err_vec_t'((1 << ERR_PCI_TABT) | (1 << ERR_TGT_APAR));
  localparam err_vec_t PERR_SEL  = err_vec_t'((1 << ERR_TGT_DPAR) | (1 << ERR_MST_DPAR));
  localparam err_vec_t LOCAL_SEL = err_vec_t'((1 << ERR_LB_UNSUP) | (1 << ERR_LB_MERR));

  localparam int RPT_W    = 3;
  localparam int RPT_SERR = 0;
  localparam int RPT_PERR = 1;
  localparam int RPT_MERR = 2;

  localparam int ADDR_W      = 2;
  localparam int ADDR_DMASK  = 0;
  localparam int ADDR_RMASK  = 1;
  localparam int ADDR_STATUS = 2;
endpackage

// File: rtl/err_detect.sv
module err_detect
  import bridge_err_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  err_vec_t evt_i,
  input  err_vec_t det_mask_i,
  input  err_vec_t clr_i,
  output err_vec_t det_o,
  output err_vec_t status_o,
  output err_vec_t status_n_o,
  output err_vec_t kept_o
);
  err_vec_t status_q;

  assign det_o      = evt_i & ~det_mask_i;
  assign kept_o     = status_q & ~clr_i;
  assign status_n_o = kept_o | det_o;
  assign status_o   = status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_n_o;
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_chk
    p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[i] && !det_mask_i[i]) |=> status_q[i]);
    p_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[i] && det_mask_i[i] && !status_q[i]) |=> !status_q[i]);
    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !evt_i[i]) |=> !status_q[i]);
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_q[i] && !clr_i[i]) |=> status_q[i]);
  end
endmodule

// File: rtl/err_first.sv
module err_first
  import bridge_err_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  err_vec_t          det_i,
  input  err_vec_t          kept_i,
  output logic              vld_o,
  output logic [TYPE_W-1:0] type_o
);
  logic              vld_q;
  logic [TYPE_W-1:0] type_q;
  logic [TYPE_W-1:0] pick;

  // lowest index wins among simultaneous errors
  always_comb begin
    pick = '0;
    for (int i = NUM_ERR - 1; i >= 0; i--) begin
      if (det_i[i]) pick = TYPE_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      type_q <= '0;
    end else if (kept_i == '0) begin
      vld_q  <= |det_i;
      type_q <= (|det_i) ? pick : '0;
    end else if (!vld_q && (|det_i)) begin
      vld_q  <= 1'b1;
      type_q <= pick;
    end
  end

  assign vld_o  = vld_q;
  assign type_o = type_q;

  p_first_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && (kept_i != '0)) |=> (vld_q && $stable(type_q)));
  p_first_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((kept_i == '0) && (det_i == '0)) |=> !vld_q);
endmodule

// File: rtl/err_report.sv
module err_report
  import bridge_err_pkg::*;
#(
  parameter int MID_W   = 4,
  localparam int NUM_MST = 1 << MID_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  err_vec_t           det_i,
  input  err_vec_t           status_i,
  input  logic [MID_W-1:0]   mid_i,
  input  logic [RPT_W-1:0]   rpt_mask_i,
  output logic               serr_no,
  output logic               perr_no,
  output logic [NUM_MST-1:0] merr_o
);
  logic [NUM_MST-1:0] vec_q;
  logic [NUM_MST-1:0] vec_base;
  logic [NUM_MST-1:0] vec_new;
  logic               local_hit;

  assign local_hit = |(det_i & LOCAL_SEL);
  assign vec_base  = ((status_i & LOCAL_SEL) == '0) ? '0 : vec_q;

  always_comb begin
    vec_new = vec_base;
    if (local_hit) vec_new[mid_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vec_q <= '0;
    else         vec_q <= vec_new;
  end

  assign serr_no = !((|(status_i & SERR_SEL)) && !rpt_mask_i[RPT_SERR]);
  assign perr_no = !((|(status_i & PERR_SEL)) && !rpt_mask_i[RPT_PERR]);
  assign merr_o  = rpt_mask_i[RPT_MERR] ? '0 : vec_q;

  p_merr_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    local_hit |=> vec_q[$past(mid_i)]);
  p_serr_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(|(status_i & SERR_SEL)) && !rpt_mask_i[RPT_SERR]) |-> !serr_no);
  p_perr_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(|(status_i & PERR_SEL)) && !rpt_mask_i[RPT_PERR]) |-> !perr_no);
  p_merr_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((status_i & LOCAL_SEL) == '0) && !local_hit) |=> (vec_q == '0));
endmodule

// File: rtl/bridge_err_unit.sv
module bridge_err_unit
  import bridge_err_pkg::*;
#(
  parameter int MID_W   = 4,
  parameter int DATA_W  = 16,
  localparam int NUM_MST = 1 << MID_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] err_evt_i,
  input  logic [MID_W-1:0]   err_mid_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [NUM_ERR-1:0] status_o,
  output logic               first_vld_o,
  output logic [TYPE_W-1:0]  first_type_o,
  output logic               serr_no,
  output logic               perr_no,
  output logic [NUM_MST-1:0] merr_o
);
  err_vec_t         det_mask_q;
  logic [RPT_W-1:0] rpt_mask_q;
  err_vec_t         clr;
  err_vec_t         det;
  err_vec_t         status_q;
  err_vec_t         status_n;
  err_vec_t         kept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_mask_q <= '0;
      rpt_mask_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_W'(ADDR_DMASK)) det_mask_q <= reg_wdata_i[NUM_ERR-1:0];
      if (reg_addr_i == ADDR_W'(ADDR_RMASK)) rpt_mask_q <= reg_wdata_i[RPT_W-1:0];
    end
  end

  assign clr = (reg_we_i && reg_addr_i == ADDR_W'(ADDR_STATUS)) ?
               reg_wdata_i[NUM_ERR-1:0] : '0;

  err_detect u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (err_evt_i),
    .det_mask_i (det_mask_q),
    .clr_i      (clr),
    .det_o      (det),
    .status_o   (status_q),
    .status_n_o (status_n),
    .kept_o     (kept)
  );

  err_first u_first (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .det_i  (det),
    .kept_i (kept),
    .vld_o  (first_vld_o),
    .type_o (first_type_o)
  );

  err_report #(.MID_W(MID_W)) u_report (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .det_i      (det),
    .status_i   (status_q),
    .mid_i      (err_mid_i),
    .rpt_mask_i (rpt_mask_q),
    .serr_no    (serr_no),
    .perr_no    (perr_no),
    .merr_o     (merr_o)
  );

  assign status_o = status_q;

  p_status_n_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_q == $past(status_n)));
endmodule

// File: tb/bridge_err_unit_tb.sv
module bridge_err_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt = '0;
  logic [3:0]  mid = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [6:0]  status;
  logic        fvld;
  logic [2:0]  ftype;
  logic        serr_n;
  logic        perr_n;
  logic [15:0] merr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bridge_err_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .err_evt_i(evt), .err_mid_i(mid),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .status_o(status), .first_vld_o(fvld), .first_type_o(ftype),
    .serr_no(serr_n), .perr_no(perr_n), .merr_o(merr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [6:0] e, input logic [3:0] m);
    @(negedge clk); evt = e; mid = m;
    @(negedge clk); evt = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic clear_all();
    wr(2'd2, 16'h007f);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status", 32'(status), 0);
    chk("R1 first_vld", 32'(fvld), 0);
    chk("R1 serr_n", 32'(serr_n), 1);
    chk("R1 perr_n", 32'(perr_n), 1);
    chk("R1 merr", 32'(merr), 0);
    pulse(7'h08, 4'd0);
    chk("R1 det mask zero", 32'(status), 32'h08);
    chk("R1 rpt mask zero", 32'(perr_n), 0);
    clear_all();
  endtask

  task automatic t_sticky_clear();
    pulse(7'h02, 4'd0);
    chk("R2 set", 32'(status), 32'h02);
    chk("R9 first type", 32'({fvld, ftype}), 32'h9);
    repeat (3) @(negedge clk);
    chk("R2 sticky", 32'(status), 32'h02);
    chk("R5 no serr for mabort", 32'(serr_n), 1);
    wr(2'd2, 16'h0000);
    chk("R4 zero write", 32'(status), 32'h02);
    wr(2'd2, 16'h0002);
    chk("R4 clear", 32'(status), 0);
    chk("R9 empty", 32'(fvld), 0);
    // set beats clear
    pulse(7'h02, 4'd0);
    @(negedge clk); we = 1'b1; addr = 2'd2; wdata = 16'h0002; evt = 7'h02;
    @(negedge clk); we = 1'b0; evt = '0;
    chk("R4 set wins", 32'(status), 32'h02);
    clear_all();
  endtask

  task automatic t_serr();
    pulse(7'h20, 4'd0);
    chk("R5 apar", 32'(serr_n), 0);
    clear_all();
    chk("R5 released", 32'(serr_n), 1);
    pulse(7'h04, 4'd0);
    chk("R5 tabort", 32'(serr_n), 0);
    wr(2'd1, 16'h0001);
    chk("R5 masked", 32'(serr_n), 1);
    pulse(7'h20, 4'd0);
    chk("R8 captured masked", 32'(status), 32'h24);
    wr(2'd1, 16'h0000);
    chk("R8 exposed", 32'(serr_n), 0);
    clear_all();
  endtask

  task automatic t_perr();
    pulse(7'h08, 4'd0);
    chk("R6 tgt dpar", 32'(perr_n), 0);
    chk("R5 no serr", 32'(serr_n), 1);
    clear_all();
    pulse(7'h10, 4'd0);
    chk("R6 mst dpar", 32'(perr_n), 0);
    wr(2'd1, 16'h0002);
    chk("R6 masked", 32'(perr_n), 1);
    wr(2'd1, 16'h0000);
    clear_all();
  endtask

  task automatic t_detmask();
    wr(2'd0, 16'h0028);
    pulse(7'h28, 4'd0);
    chk("R3 status", 32'(status), 0);
    chk("R3 perr", 32'(perr_n), 1);
    chk("R3 serr", 32'(serr_n), 1);
    chk("R3 first", 32'(fvld), 0);
    wr(2'd0, 16'h0041);
    pulse(7'h40, 4'd3);
    @(negedge clk);
    chk("R3 merr", 32'(merr), 0);
    wr(2'd0, 16'h0000);
    clear_all();
  endtask

  task automatic t_merr();
    pulse(7'h40, 4'd5);
    chk("R7 mid5", 32'(merr), 32'h0020);
    pulse(7'h01, 4'd9);
    chk("R7 mid9", 32'(merr), 32'h0220);
    wr(2'd1, 16'h0004);
    chk("R7 masked", 32'(merr), 0);
    chk("R8 status", 32'(status), 32'h41);
    wr(2'd1, 16'h0000);
    chk("R8 vector kept", 32'(merr), 32'h0220);
    wr(2'd2, 16'h0001);
    @(negedge clk);
    chk("R7 partial clear", 32'(merr), 32'h0220);
    wr(2'd2, 16'h0040);
    @(negedge clk);
    chk("R7 cleared", 32'(merr), 0);
    clear_all();
  endtask

  task automatic t_first();
    pulse(7'h14, 4'd0);
    chk("R9 lowest wins", 32'({fvld, ftype}), 32'hA);
    pulse(7'h02, 4'd0);
    chk("R9 held", 32'({fvld, ftype}), 32'hA);
    wr(2'd2, 16'h0004);
    chk("R9 held after partial", 32'({fvld, ftype}), 32'hA);
    clear_all();
    chk("R9 invalid", 32'(fvld), 0);
    pulse(7'h40, 4'd1);
    chk("R9 recapture", 32'({fvld, ftype}), 32'hE);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky_clear();
    t_serr();
    t_perr();
    t_detmask();
    t_merr();
    t_first();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule